// File: doc/BRIEF.md
# Flash Block Lock Protection Controller

This block keeps the write-protection state of every erase block in a multi-bank flash array and rules on each program or erase request before the array is touched. Commands arrive one per cycle on a small command interface carrying an operation code, a block address and a data word. Lock, unlock and lock-down commands change the state of the addressed block at once, so the very next request already sees the new state. Program and erase requests are granted only when the block is open, the decoded program-voltage level is above lockout and no earlier operation is still running.

A hardware write-protect input, active low, freezes the lock bit of every block that has been locked down. Lock-down itself is retained until reset. The voltage level is looked at only in the cycle a program or erase is accepted; the operation timer then runs to completion whatever the level does. Every refused command sets a sticky error flag, and the state of any block can be read through an address-indexed status port. A block address beyond the configured block count is always refused and reads back as locked.

Top module: `flash_lock_guard`

## Requirements
- R1: While rst_n is low, rsp_valid, rsp_grant, err_flag, busy, op_done, rd_state and cfg_q are all 0; after reset every block reads back as locked (2'b01).
- R2: Block state is two bits, bit 0 = locked, bit 1 = locked down (00 open, 01 locked, 10 locked down but open, 11 locked down and locked); op codes are 1 lock (sets bit 0), 2 unlock (clears bit 0), 3 lock-down (sets both bits), 4 program, 5 erase, 6 clear error, 7 load configuration, 0 no operation.
- R3: With wp_n low, lock and unlock on a block whose bit 1 is set are refused and leave its state unchanged.
- R4: With wp_n high, lock and unlock on a locked-down block change bit 0 only; bit 1 is cleared only by reset.
- R5: A state change takes effect with zero latency: a program on a block issued in the cycle right after the unlock of that block is granted.
- R6: Each lock, unlock, lock-down, program or erase gets exactly one response, rsp_valid high for one cycle after the edge that samples the command, with rsp_grant telling whether it was accepted; program and erase are refused on a block with bit 0 set.
- R7: A program or erase is refused when vpp_lvl is 2'b00 (below lockout), whatever the block state; levels 2'b01 and 2'b10 permit it.
- R8: A granted program or erase holds busy high for OP_LEN cycles, then pulses op_done for one cycle; a change of vpp_lvl after acceptance has no effect on this.
- R9: A program or erase requested while busy is high is refused.
- R10: Every refused command sets err_flag at its response edge, and err_flag stays set until a clear-error command.
- R11: rd_state shows the state of block rd_blk one cycle after rd_blk is presented.
- R12: The load-configuration command copies cmd_data into cfg_q at the next edge; reset returns cfg_q to 0, which selects asynchronous read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_blk | input | BLK_AW | Target block address |
| cmd_data | input | CFG_W | Configuration word for op 7 |
| wp_n | input | 1 | Write-protect pin, low freezes locked-down blocks |
| vpp_lvl | input | 2 | Decoded program-voltage level, 00 lockout, 01 logic range, 10 high range |
| rd_blk | input | BLK_AW | Status read address |
| rd_state | output | 2 | State of the block addressed one cycle earlier |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Command accepted |
| err_flag | output | 1 | Sticky protection error |
| busy | output | 1 | Program or erase in progress |
| op_done | output | 1 | One-cycle pulse when the operation ends |
| cfg_q | output | CFG_W | Configuration register |

## Verification
A command driven between edges is sampled at the next rising edge, and its response, any error-flag change, the new block state and cfg_q are all visible right after that same edge; the scoreboard queues one expected grant per response-bearing command and its monitor pops it one time unit after the next rising edge, so a late, early or missing response fails. rd_state is checked one time unit after the edge that follows the change of rd_blk, and also just before that edge to prove it has not moved yet. After an accepted program, busy is checked high right after the accepting edge and again after OP_LEN-1 further edges, and op_done is expected after exactly OP_LEN edges, with vpp_lvl pulled to lockout in between.

// File: rtl/flg_pkg.sv
package flg_pkg;

   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_LOCK   = 3'd1,
      OP_UNLOCK = 3'd2,
      OP_LDOWN  = 3'd3,
      OP_PROG   = 3'd4,
      OP_ERASE  = 3'd5,
      OP_CLR    = 3'd6,
      OP_CFG    = 3'd7
   } flg_op_e;

   // bit 0: locked, bit 1: locked down
   typedef logic [1:0] blk_st_t;

   localparam blk_st_t ST_OPEN    = 2'b00;
   localparam blk_st_t ST_LOCKED  = 2'b01;
   localparam blk_st_t ST_LD_OPEN = 2'b10;
   localparam blk_st_t ST_LD_SHUT = 2'b11;

   localparam logic [1:0] VPP_LOCKOUT = 2'b00;

   function automatic logic is_lock_cmd(input flg_op_e op);
      return (op == OP_LOCK) || (op == OP_UNLOCK) || (op == OP_LDOWN);
   endfunction

   function automatic logic is_pe_cmd(input flg_op_e op);
      return (op == OP_PROG) || (op == OP_ERASE);
   endfunction

endpackage

// File: rtl/flg_blk_array.sv
module flg_blk_array
   import flg_pkg::*;
#(
   parameter int NUM_BLK = 16,
   parameter int BLK_AW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BLK_AW-1:0] wr_blk,
   input  blk_st_t           wr_val,
   input  logic [BLK_AW-1:0] sel_blk,
   output blk_st_t           sel_state,
   output logic              sel_ok,
   input  logic [BLK_AW-1:0] rd_blk,
   output blk_st_t           rd_state
);

   localparam bit FULL_MAP = (NUM_BLK == (1 << BLK_AW));

   blk_st_t st_all [NUM_BLK];
   blk_st_t rd_next;

   for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
      blk_st_t st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st_q <= ST_LOCKED;
         else if (wr_en && (wr_blk == BLK_AW'(g)))
            st_q <= wr_val;
      end
      assign st_all[g] = st_q;
   end

   if (FULL_MAP) begin : g_full
      assign sel_state = st_all[sel_blk];
      assign sel_ok    = 1'b1;
      assign rd_next   = st_all[rd_blk];
   end else begin : g_part
      logic sel_in, rd_in;
      assign sel_in    = (32'(sel_blk) < NUM_BLK);
      assign rd_in     = (32'(rd_blk) < NUM_BLK);
      assign sel_state = sel_in ? st_all[sel_blk] : ST_LOCKED;
      assign sel_ok    = sel_in;
      assign rd_next   = rd_in ? st_all[rd_blk] : ST_LOCKED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_state <= ST_OPEN;
      else
         rd_state <= rd_next;
   end

endmodule

// File: rtl/flg_decide.sv
module flg_decide
   import flg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  blk_st_t    sel_state,
   input  logic       sel_ok,
   input  logic       wp_n,
   input  logic [1:0] vpp_lvl,
   input  logic       busy,
   output logic       wr_en,
   output blk_st_t    wr_val,
   output logic       start_op,
   output logic       rsp_valid,
   output logic       rsp_grant,
   output logic       err_flag
);

   flg_op_e op;
   logic    frozen, ok, has_rsp;

   assign op      = flg_op_e'(cmd_op);
   assign frozen  = sel_state[1] && !wp_n;
   assign has_rsp = cmd_valid && (is_lock_cmd(op) || is_pe_cmd(op));

   always_comb begin
      ok     = 1'b0;
      wr_val = sel_state;
      unique case (op)
         OP_LOCK: begin
            wr_val = {sel_state[1], 1'b1};
            ok     = sel_ok && !frozen;
         end
         OP_UNLOCK: begin
            wr_val = {sel_state[1], 1'b0};
            ok     = sel_ok && !frozen;
         end
         OP_LDOWN: begin
            wr_val = ST_LD_SHUT;
            ok     = sel_ok;
         end
         OP_PROG, OP_ERASE:
            ok = sel_ok && !sel_state[0] && (vpp_lvl != VPP_LOCKOUT) && !busy;
         default: ok = 1'b0;
      endcase
   end

   assign wr_en    = cmd_valid && is_lock_cmd(op) && ok;
   assign start_op = cmd_valid && is_pe_cmd(op) && ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         rsp_valid <= has_rsp;
         rsp_grant <= has_rsp && ok;
         if (has_rsp && !ok)
            err_flag <= 1'b1;
         else if (cmd_valid && (op == OP_CLR))
            err_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/flg_op_timer.sv
module flg_op_timer #(
   parameter int OP_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int CNT_W = (OP_LEN > 2) ? $clog2(OP_LEN) : 1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt_q == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(OP_LEN - 1);
         end
      end
   end

endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
   import flg_pkg::*;
#(
   parameter int NUM_BLK = 16,
   parameter int BLK_AW  = $clog2(NUM_BLK),
   parameter int CFG_W   = 16,
   parameter int OP_LEN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [BLK_AW-1:0] cmd_blk,
   input  logic [CFG_W-1:0]  cmd_data,
   input  logic              wp_n,
   input  logic [1:0]        vpp_lvl,
   input  logic [BLK_AW-1:0] rd_blk,
   output logic [1:0]        rd_state,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              err_flag,
   output logic              busy,
   output logic              op_done,
   output logic [CFG_W-1:0]  cfg_q
);

   if (NUM_BLK < 2) begin : g_bad_blk
      $error("flash_lock_guard: NUM_BLK must be at least 2");
   end
   if ((1 << BLK_AW) < NUM_BLK) begin : g_bad_aw
      $error("flash_lock_guard: BLK_AW too narrow for NUM_BLK");
   end
   if (OP_LEN < 2) begin : g_bad_len
      $error("flash_lock_guard: OP_LEN must be at least 2");
   end
   if (CFG_W < 1) begin : g_bad_cfg
      $error("flash_lock_guard: CFG_W must be at least 1");
   end

   blk_st_t sel_state, wr_val;
   logic    sel_ok, wr_en, start_op;

   flg_blk_array #(
      .NUM_BLK (NUM_BLK),
      .BLK_AW  (BLK_AW)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_blk    (cmd_blk),
      .wr_val    (wr_val),
      .sel_blk   (cmd_blk),
      .sel_state (sel_state),
      .sel_ok    (sel_ok),
      .rd_blk    (rd_blk),
      .rd_state  (rd_state)
   );

   flg_decide u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .sel_state (sel_state),
      .sel_ok    (sel_ok),
      .wp_n      (wp_n),
      .vpp_lvl   (vpp_lvl),
      .busy      (busy),
      .wr_en     (wr_en),
      .wr_val    (wr_val),
      .start_op  (start_op),
      .rsp_valid (rsp_valid),
      .rsp_grant (rsp_grant),
      .err_flag  (err_flag)
   );

   flg_op_timer #(
      .OP_LEN (OP_LEN)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_op),
      .busy  (busy),
      .done  (op_done)
   );

   // cleared value 0 selects asynchronous read mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (cmd_valid && (flg_op_e'(cmd_op) == OP_CFG))
         cfg_q <= cmd_data;
   end

endmodule

// File: rtl/flg_guard_chk.sv
module flg_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic [1:0] vpp_lvl,
   input logic       rsp_valid,
   input logic       rsp_grant,
   input logic       err_flag,
   input logic       busy,
   input logic       op_done
);

   logic rsp_cmd, pe_cmd;
   assign rsp_cmd = cmd_valid && (cmd_op inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5});
   assign pe_cmd  = cmd_valid && (cmd_op inside {3'd4, 3'd5});

   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cmd |=> rsp_valid);  // R6

   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_cmd |=> !rsp_valid);  // R6

   AST_LOCKOUT_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_cmd && vpp_lvl == 2'b00) |=> (rsp_valid && !rsp_grant));  // R7

   AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_cmd && busy) |=> !rsp_grant);  // R9

   AST_REFUSAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_grant) |-> err_flag);  // R10

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(cmd_valid && cmd_op == 3'd6)) |=> err_flag);  // R10

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |-> ($past(busy) && !busy));  // R8

   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> op_done);  // R8

endmodule

bind flash_lock_guard flg_guard_chk u_guard_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .vpp_lvl   (vpp_lvl),
   .rsp_valid (rsp_valid),
   .rsp_grant (rsp_grant),
   .err_flag  (err_flag),
   .busy      (busy),
   .op_done   (op_done)
);

// File: tb/flash_lock_guard_test.sv
`timescale 1ns/1ps
module flash_lock_guard_test;

   localparam int NB = 16;
   localparam int AW = 4;
   localparam int CW = 16;
   localparam int OPL = 8;

   localparam logic [2:0] C_NOP = 3'd0, C_LOCK = 3'd1, C_UNLOCK = 3'd2, C_LDOWN = 3'd3;
   localparam logic [2:0] C_PROG = 3'd4, C_ERASE = 3'd5, C_CLR = 3'd6, C_CFG = 3'd7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = C_NOP;
   logic [AW-1:0] cmd_blk = '0;
   logic [CW-1:0] cmd_data = '0;
   logic          wp_n = 1'b1;
   logic [1:0]    vpp_lvl = 2'b01;
   logic [AW-1:0] rd_blk = '0;
   logic [1:0]    rd_state;
   logic          rsp_valid, rsp_grant, err_flag, busy, op_done;
   logic [CW-1:0] cfg_q;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   flash_lock_guard uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_blk(cmd_blk), .cmd_data(cmd_data), .wp_n(wp_n), .vpp_lvl(vpp_lvl),
      .rd_blk(rd_blk), .rd_state(rd_state), .rsp_valid(rsp_valid),
      .rsp_grant(rsp_grant), .err_flag(err_flag), .busy(busy),
      .op_done(op_done), .cfg_q(cfg_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   endtask

   // driver: one command per negedge, expectation queued when a response is due
   task automatic cmd(input logic [2:0] op, input int blk, input logic [CW-1:0] d,
                      input bit has_rsp, input bit grant, input string req);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_blk   = AW'(blk);
      cmd_data  = d;
      if (has_rsp) begin
         exp_q.push_back(grant);
         tag_q.push_back(req);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = C_NOP;
   endtask

   task automatic rd_chk(input int blk, input logic [1:0] exp, input string req);
      @(negedge clk);
      rd_blk = AW'(blk);
      @(posedge clk);
      #1;
      chk(req, 32'(rd_state), 32'(exp));
   endtask

   task automatic sig_chk(input string req, input logic act, input logic exp);
      chk(req, 32'(act), 32'(exp));
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4 * OPL; i++) begin
         @(posedge clk);
         #1;
         if (op_done) break;
      end
   endtask

   // monitor: every response is due one edge after its command
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               chk("R6 unexpected response", 32'(rsp_valid), 32'd0);
            end else begin
               chk({tag_q.pop_front(), " grant"}, 32'(rsp_grant), 32'(exp_q.pop_front()));
            end
         end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            chk({tag_q.pop_front(), " missing response"}, 32'(rsp_valid), 32'd1);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n     = 1'b0;
      cmd_valid = 1'b0;
      cmd_op    = C_NOP;
      repeat (2) @(posedge clk);
      #1;
      sig_chk("R1 rsp_valid in reset", rsp_valid, 1'b0);
      sig_chk("R1 busy in reset", busy, 1'b0);
      sig_chk("R1 err_flag in reset", err_flag, 1'b0);
      chk("R1 rd_state in reset", 32'(rd_state), 32'd0);
      chk("R12 cfg_q in reset", 32'(cfg_q), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();

      // R1: every block comes up locked
      for (int b = 0; b < NB; b++) rd_chk(b, 2'b01, "R1 block locked after reset");

      // R6 program on locked block is refused, R10 flag sticks
      cmd(C_PROG, 3, '0, 1, 0, "R6 program on locked block");
      idle();
      sig_chk("R10 err set after refusal", err_flag, 1'b1);
      idle();
      sig_chk("R10 err stays set", err_flag, 1'b1);
      cmd(C_CLR, 0, '0, 0, 0, "");
      idle();
      sig_chk("R10 err cleared", err_flag, 1'b0);

      // R5 unlock then program next cycle; R8 timing with vpp dropping
      cmd(C_UNLOCK, 3, '0, 1, 1, "R2 unlock");
      cmd(C_PROG, 3, '0, 1, 1, "R5 program right after unlock");
      @(posedge clk);
      #1;
      sig_chk("R8 busy after accept", busy, 1'b1);
      vpp_lvl = 2'b00;
      idle();
      repeat (OPL - 1) @(posedge clk);
      #1;
      sig_chk("R8 busy held", busy, 1'b1);
      sig_chk("R8 no early done", op_done, 1'b0);
      @(posedge clk);
      #1;
      sig_chk("R8 busy ends", busy, 1'b0);
      sig_chk("R8 done pulse", op_done, 1'b1);
      @(posedge clk);
      #1;
      sig_chk("R8 done one cycle", op_done, 1'b0);
      rd_chk(3, 2'b00, "R2 block open after unlock");

      // R7 lockout refuses even an open block
      cmd(C_ERASE, 3, '0, 1, 0, "R7 erase at lockout");
      idle();
      cmd(C_CLR, 0, '0, 0, 0, "");
      vpp_lvl = 2'b10;
      cmd(C_ERASE, 3, '0, 1, 1, "R7 erase at high level");
      idle();
      wait_done();
      sig_chk("R7 erase completed", op_done, 1'b1);
      vpp_lvl = 2'b01;

      // R9 request while busy
      cmd(C_UNLOCK, 7, '0, 1, 1, "R9 unlock second block");
      cmd(C_PROG, 3, '0, 1, 1, "R9 first program");
      cmd(C_PROG, 7, '0, 1, 0, "R9 program while busy");
      idle();
      sig_chk("R9 refusal flagged", err_flag, 1'b1);
      wait_done();
      cmd(C_CLR, 0, '0, 0, 0, "");
      idle();

      // R2 R3 R4 lock-down and protect pin
      cmd(C_LDOWN, 5, '0, 1, 1, "R2 lock-down");
      idle();
      rd_chk(5, 2'b11, "R2 locked down and locked");
      wp_n = 1'b0;
      cmd(C_UNLOCK, 5, '0, 1, 0, "R3 unlock frozen");
      cmd(C_LOCK, 5, '0, 1, 0, "R3 lock frozen");
      idle();
      rd_chk(5, 2'b11, "R3 state unchanged");
      cmd(C_CLR, 0, '0, 0, 0, "");
      wp_n = 1'b1;
      cmd(C_UNLOCK, 5, '0, 1, 1, "R4 unlock with pin high");
      idle();
      rd_chk(5, 2'b10, "R4 lock-down kept, open");
      cmd(C_PROG, 5, '0, 1, 1, "R4 program open locked-down block");
      idle();
      wait_done();
      cmd(C_LOCK, 5, '0, 1, 1, "R4 relock with pin high");
      idle();
      rd_chk(5, 2'b11, "R4 relocked");
      wp_n = 1'b0;
      cmd(C_UNLOCK, 5, '0, 1, 0, "R3 frozen again");
      idle();
      cmd(C_CLR, 0, '0, 0, 0, "");
      wp_n = 1'b1;
      idle();

      // R2 lock on open block
      cmd(C_LOCK, 7, '0, 1, 1, "R2 lock");
      idle();
      rd_chk(7, 2'b01, "R2 locked state");

      // R11 one-cycle latency of the status port
      rd_chk(5, 2'b11, "R11 read block 5");
      @(negedge clk);
      rd_blk = AW'(3);
      #1;
      chk("R11 old value before edge", 32'(rd_state), 32'd3);
      @(posedge clk);
      #1;
      chk("R11 new value after edge", 32'(rd_state), 32'd0);

      // R12 configuration register
      cmd(C_CFG, 0, 16'hA5C3, 0, 0, "");
      idle();
      chk("R12 cfg loaded", 32'(cfg_q), 32'hA5C3);

      do_reset();
      rd_chk(5, 2'b01, "R4 reset clears lock-down");
      rd_chk(3, 2'b01, "R1 reset relocks block");
      chk("R12 cfg cleared after reset", 32'(cfg_q), 32'd0);
      sig_chk("R1 err clear after reset", err_flag, 1'b0);

      repeat (3) @(posedge clk);
      #1;
      chk("R6 all responses consumed", 32'(exp_q.size()), 32'd0);
      finish_run();
   end

endmodule